// File: doc/BRIEF.md
# Scrolled Text-Mode Cell Renderer

This block turns a byte-wide video RAM into a coloured 8x8-cell text display. It takes the pixel counters from an external raster timing generator and adds two scroll offsets to them, wrapping modulo 1024. The scrolled position then picks a window into a 128x128 plane of character cells. For every 8-pixel cell it runs a fixed schedule of three RAM reads. The first read fetches the character code of the next cell. The second fetches that cell's colour byte. The third fetches one glyph row, using the code it has just read. These three reads occupy six of the eight pixel clocks. The remaining two clocks are flagged as free, so that a separate writer can use the RAM port.

The fetched data waits in staging registers. At the last pixel of the current cell it moves into the display registers. From there a glyph bit selects, pixel by pixel, either the foreground nibble or the background nibble of the colour byte. This nibble is the 4-bit RGBI output. The fetch always targets the next cell, so the external timing must present the last cell before the visible area early enough for the first visible cell to be ready.

The RAM is synchronous. An address driven in one cycle is captured by the RAM at the following edge, and the block latches the data one edge after that.

Top module: `txt_render`

## Requirements
- R1: The block forms sx = (pix_x + scroll_x) mod 1024 and sy = (pix_y + scroll_y) mod 1024. The cell phase is sx[2:0]. Every output below is a function of these sampled values at a clock edge.
- R2: After an edge that samples phase 0, ram_rd is 1 and ram_addr is {2'b00, sy[9:3], (sx[9:3]+1) mod 128, 1'b0}. This is the code read for the next cell.
- R3: After an edge that samples phase 2, ram_rd is 1 and ram_addr is {2'b00, sy[9:3], (sx[9:3]+1) mod 128, 1'b1}. This is the colour read.
- R4: After an edge that samples phase 4, ram_rd is 1 and ram_addr is {2'b01, 4'b0000, code, sy[2:0]}. Here code is the byte latched at the last phase-2 edge.
- R5: After an edge that samples phase 1, 3, 5, 6 or 7, ram_rd is 0 and ram_addr keeps its previous value.
- R6: free_slot is 1 exactly after edges that sample phase 6 or 7. It is never 1 together with ram_rd.
- R7: ram_rdata is latched at the edges that sample phases 2, 4 and 6. Phase 2 latches the code, phase 4 latches the colour into staging, and phase 6 latches the glyph row into staging.
- R8: Both staged bytes move into the display registers only at an edge that samples phase 7. At every other edge the display registers keep their value.
- R9: After each edge, rgbi shows the pixel at the sampled phase p. If display glyph bit (7-p) is set, rgbi is colour[7:4] (foreground). Otherwise rgbi is colour[3:0] (background). Bit 7 is the leftmost pixel.
- R10: After an edge that samples blank = 1, rgbi is 0.
- R11: Synchronous reset clears ram_addr, ram_rd, free_slot, rgbi, the latched code and all staging and display registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Horizontal pixel counter |
| pix_y | input | 10 | Vertical line counter |
| blank | input | 1 | High outside the visible area |
| scroll_x | input | 10 | Horizontal scroll offset |
| scroll_y | input | 10 | Vertical scroll offset |
| ram_rdata | input | 8 | Read data from the synchronous video RAM |
| ram_addr | output | 17 | Registered RAM address |
| ram_rd | output | 1 | Registered read strobe |
| free_slot | output | 1 | RAM port unused by the fetch this cycle |
| rgbi | output | 4 | Registered RGBI pixel colour |

## Verification
Some properties are checked on every cycle. A read strobe never coincides with the free-slot flag. A glyph-region address always has a zero pad field. A blanked input always produces a black pixel on the next cycle. The display registers change only when the promote signal from the fetch sequencer fires.

Other behaviour can only be shown by the bench scenarios. These cover the exact address each phase produces under different scroll offsets, and wrap-around at the 1024 and 128-cell boundaries. They also cover the one-cell latency between a fetch and its display, the foreground/background choice across real glyph rows, and recovery after a phase jump caused by a mid-line scroll change.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int ADDR_W    = 17;
  localparam int BYTE_W    = 8;
  localparam int CELL_BITS = 3;
  localparam int CIDX_W    = 7;

  typedef logic [ADDR_W-1:0] vaddr_t;
  typedef logic [CELL_BITS-1:0] phase_t;

  localparam phase_t PH_CODE_A  = 3'd0;
  localparam phase_t PH_CODE_L  = 3'd2;
  localparam phase_t PH_COL_A   = 3'd2;
  localparam phase_t PH_COL_L   = 3'd4;
  localparam phase_t PH_GLY_A   = 3'd4;
  localparam phase_t PH_GLY_L   = 3'd6;
  localparam phase_t PH_PROMOTE = 3'd7;

  function automatic vaddr_t cell_addr(input logic [CIDX_W-1:0] cy,
                                       input logic [CIDX_W-1:0] cx,
                                       input logic sel_col);
    return {2'b00, cy, cx, sel_col};
  endfunction

  function automatic vaddr_t glyph_addr(input logic [BYTE_W-1:0] code,
                                        input logic [CELL_BITS-1:0] row);
    return {2'b01, 4'b0000, code, row};
  endfunction
endpackage

// File: rtl/txt_scroll_add.sv
module txt_scroll_add #(
  parameter int W = 10
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] ofs,
  output logic [W-1:0] sum
);
  // Wraps modulo 2**W (R1)
  always_comb sum = cnt + ofs;
endmodule

// File: rtl/txt_fetch_seq.sv
module txt_fetch_seq
  import txt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  sx,
  input  logic [CNT_W-1:0]  sy,
  input  logic [BYTE_W-1:0] rdata,
  output vaddr_t            ram_addr,
  output logic              ram_rd,
  output logic              free_slot,
  output logic              promote,
  output logic [BYTE_W-1:0] stg_col,
  output logic [BYTE_W-1:0] stg_gly
);
  localparam int CX_W = CNT_W - CELL_BITS;

  phase_t            phase;
  logic [CX_W-1:0]   next_cx;
  logic [CX_W-1:0]   cur_cy;
  logic [BYTE_W-1:0] code_q;

  always_comb begin
    phase   = sx[CELL_BITS-1:0];
    next_cx = sx[CNT_W-1:CELL_BITS] + 1'b1;
    cur_cy  = sy[CNT_W-1:CELL_BITS];
    promote = (phase == PH_PROMOTE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_rd    <= 1'b0;
      free_slot <= 1'b0;
      code_q    <= '0;
      stg_col   <= '0;
      stg_gly   <= '0;
    end else begin
      ram_rd    <= (phase == PH_CODE_A) || (phase == PH_COL_A) || (phase == PH_GLY_A);
      free_slot <= (phase == 3'd6) || (phase == 3'd7);
      case (phase)
        PH_CODE_A: ram_addr <= cell_addr(cur_cy, next_cx, 1'b0);
        PH_COL_A:  ram_addr <= cell_addr(cur_cy, next_cx, 1'b1);
        PH_GLY_A:  ram_addr <= glyph_addr(code_q, sy[CELL_BITS-1:0]);
        default:   ram_addr <= ram_addr;
      endcase
      if (phase == PH_CODE_L) code_q  <= rdata;
      if (phase == PH_COL_L)  stg_col <= rdata;
      if (phase == PH_GLY_L)  stg_gly <= rdata;
    end
  end

  assert_rd_not_free_R6: assert property (@(posedge clk) disable iff (rst)
    ram_rd |-> !free_slot);

  assert_glyph_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (ram_rd && ram_addr[15]) |-> (ram_addr[16] == 1'b0 && ram_addr[14:11] == 4'b0000));
endmodule

// File: rtl/txt_pixel_out.sv
module txt_pixel_out
  import txt_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              blank,
  input  logic              promote,
  input  logic [BYTE_W-1:0] stg_col,
  input  logic [BYTE_W-1:0] stg_gly,
  output logic [COL_W-1:0]  rgbi
);
  logic [BYTE_W-1:0] disp_col;
  logic [BYTE_W-1:0] disp_gly;
  logic              fg_sel;
  phase_t            bit_idx;

  always_comb begin
    bit_idx = 3'd7 - phase;
    fg_sel  = disp_gly[bit_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_col <= '0;
      disp_gly <= '0;
      rgbi     <= '0;
    end else begin
      if (promote) begin
        disp_col <= stg_col;
        disp_gly <= stg_gly;
      end
      if (blank)       rgbi <= '0;
      else if (fg_sel) rgbi <= disp_col[2*COL_W-1:COL_W];
      else             rgbi <= disp_col[COL_W-1:0];
    end
  end

  assert_disp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !promote |=> ($stable(disp_col) && $stable(disp_gly)));

  assert_blank_black_R10: assert property (@(posedge clk) disable iff (rst)
    blank |=> (rgbi == '0));
endmodule

// File: rtl/txt_render.sv
module txt_render
  import txt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int COL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  pix_x,
  input  logic [CNT_W-1:0]  pix_y,
  input  logic              blank,
  input  logic [CNT_W-1:0]  scroll_x,
  input  logic [CNT_W-1:0]  scroll_y,
  input  logic [7:0]        ram_rdata,
  output logic [16:0]       ram_addr,
  output logic              ram_rd,
  output logic              free_slot,
  output logic [COL_W-1:0]  rgbi
);
  logic [CNT_W-1:0]  sx, sy;
  logic              promote;
  logic [BYTE_W-1:0] stg_col, stg_gly;

  txt_scroll_add #(.W(CNT_W)) u_add_x (.cnt(pix_x), .ofs(scroll_x), .sum(sx));
  txt_scroll_add #(.W(CNT_W)) u_add_y (.cnt(pix_y), .ofs(scroll_y), .sum(sy));

  txt_fetch_seq #(.CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .sx(sx), .sy(sy), .rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .free_slot(free_slot),
    .promote(promote), .stg_col(stg_col), .stg_gly(stg_gly)
  );

  txt_pixel_out #(.COL_W(COL_W)) u_pix (
    .clk(clk), .rst(rst), .phase(sx[CELL_BITS-1:0]), .blank(blank),
    .promote(promote), .stg_col(stg_col), .stg_gly(stg_gly), .rgbi(rgbi)
  );
endmodule

// File: tb/txt_render_test.sv
module txt_render_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] pix_x = '0, pix_y = '0, scroll_x = '0, scroll_y = '0;
  logic blank = 1'b0;
  logic [7:0] ram_q = '0;
  logic [16:0] ram_addr;
  logic ram_rd, free_slot;
  logic [3:0] rgbi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int m_code = 0, m_scol = 0, m_sgly = 0, m_dcol = 0, m_dgly = 0;
  int e_addr = 0, e_rd = 0, e_free = 0, e_rgbi = 0;
  bit e_blank = 0;
  int e_phase = 0;
  bit e_rst = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_render uut (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .blank(blank),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .ram_rdata(ram_q),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .free_slot(free_slot), .rgbi(rgbi)
  );

  function automatic int memf(input int a);
    return ((a * 29) ^ (a >> 7) ^ (a >> 13) ^ 8'h5A) & 255;
  endfunction

  // Behavioural synchronous RAM
  always @(posedge clk) if (ram_rd) ram_q <= 8'(memf(int'(ram_addr)));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (e_rst) begin
      check(ram_addr == 17'(e_addr), "R11 addr", int'(ram_addr), e_addr);
      check(ram_rd == 1'b0, "R11 rd", int'(ram_rd), 0);
      check(free_slot == 1'b0, "R11 free", int'(free_slot), 0);
      check(rgbi == 4'd0, "R11 rgbi", int'(rgbi), 0);
      return;
    end
    if (e_phase == 0)      check(ram_addr == 17'(e_addr), "R2 code addr", int'(ram_addr), e_addr);
    else if (e_phase == 2) check(ram_addr == 17'(e_addr), "R3 colour addr", int'(ram_addr), e_addr);
    else if (e_phase == 4) check(ram_addr == 17'(e_addr), "R4 glyph addr", int'(ram_addr), e_addr);
    else                   check(ram_addr == 17'(e_addr), "R5 addr hold", int'(ram_addr), e_addr);
    check(int'(ram_rd) == e_rd, "R5 read strobe", int'(ram_rd), e_rd);
    check(int'(free_slot) == e_free, "R6 free slot", int'(free_slot), e_free);
    // rgbi depends on R7 capture and R8 promotion timing
    if (e_blank) check(int'(rgbi) == e_rgbi, "R10 blank rgbi", int'(rgbi), e_rgbi);
    else         check(int'(rgbi) == e_rgbi, "R9 pixel rgbi (R7/R8)", int'(rgbi), e_rgbi);
  endtask

  // One clock: compare previous expectations, drive inputs, predict next
  task automatic step(input bit r, input int x, input int y, input int scx, input int scy, input bit bl);
    int sx, sy, p, ncx, q;
    @(negedge clk);
    compare();
    rst = r; pix_x = 10'(x); pix_y = 10'(y); scroll_x = 10'(scx); scroll_y = 10'(scy); blank = bl;
    q = int'(ram_q);
    if (r) begin
      e_rst = 1; e_addr = 0;
      m_code = 0; m_scol = 0; m_sgly = 0; m_dcol = 0; m_dgly = 0;
      return;
    end
    e_rst = 0;
    // R1: scrolled coordinates wrap modulo 1024
    sx = (x + scx) % 1024;
    sy = (y + scy) % 1024;
    p = sx % 8;
    ncx = ((sx / 8) + 1) % 128;
    e_phase = p;
    e_blank = bl;
    if (bl) e_rgbi = 0;
    else if (((m_dgly >> (7 - p)) & 1) != 0) e_rgbi = m_dcol >> 4;
    else e_rgbi = m_dcol & 15;
    e_rd = (p == 0 || p == 2 || p == 4) ? 1 : 0;
    e_free = (p >= 6) ? 1 : 0;
    if (p == 0) e_addr = ((sy / 8) << 8) | (ncx << 1);
    if (p == 2) e_addr = ((sy / 8) << 8) | (ncx << 1) | 1;
    if (p == 4) e_addr = (1 << 15) | (m_code << 3) | (sy % 8);
    if (p == 7) begin m_dcol = m_scol; m_dgly = m_sgly; end
    if (p == 2) m_code = q;
    if (p == 4) m_scol = q;
    if (p == 6) m_sgly = q;
  endtask

  task automatic run_lines(input int y0, input int n, input int scx, input int scy);
    for (int l = 0; l < n; l++)
      for (int x = 0; x < 800; x++)
        step(0, x, (y0 + l) % 525, scx, scy, (x >= 640) || (((y0 + l) % 525) >= 480));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);   // R11 reset state
    run_lines(0, 3, 0, 0);                                 // plain raster
    run_lines(100, 2, 13, 5);                              // odd scroll offsets
    run_lines(478, 4, 1000, 1020);                         // wrap of 1024 and cell 127, vertical blank
    // phase jump: scroll_x changes mid-line
    for (int x = 0; x < 300; x++) step(0, x, 10, 7, 0, 0);
    for (int x = 300; x < 800; x++) step(0, x, 10, 3, 0, x >= 640);
    run_lines(11, 1, 3, 0);
    for (int i = 0; i < 3; i++) step(1, 5, 5, 0, 0, 0);    // R11 mid-run reset
    run_lines(200, 2, 517, 333);
    step(0, 0, 0, 0, 0, 1);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule